// File: doc/BRIEF.md
# Program Status Read Multiplexer

This block sits in the read path of a sector-programmed flash macro and chooses the word a read returns. When no program cycle is running, a read returns the array word, or a fixed identification code while identification mode is on. While the internal program cycle is busy, every read becomes a status poll. Two independent indicators then appear in each byte lane at the same time. The top bit of each lane carries the inverse of the matching bit of the word loaded last. The next bit down flips once for every new read access.

A read access is the time during which chip select and output enable are both active. A new access begins at the rising edge of that combined strobe, so it does not matter whether output enable, chip select or both were released and asserted again. All inputs are sampled on the clock. The result is registered and appears one cycle after the inputs, together with a drive qualifier that tells the pad logic when to enable the output.

Top module: `flash_rdmux`

## Requirements
- R1: `rd_word` and `rd_drive` are registered. When `sel` and `oe` were not both high at the previous edge, `rd_word` is 0 and `rd_drive` is 0 one cycle later. When both were high, `rd_drive` is 1. Both are 0 during reset.
- R2: For a read with `busy` low and `id_mode` low, the next cycle's `rd_word` equals the `array_word` sampled with that read.
- R3: For a read with `busy` high, bits 7 and 15 of the result are the inverse of bits 7 and 15 of `last_word`.
- R4: While `busy` stays high, a toggle bit inverts at each new read access and keeps its value while the strobe is held. It is returned in bits 6 and 14.
- R5: A new read access is the rising edge of (`sel` AND `oe`). Toggling `oe` alone, `sel` alone, or both starts one.
- R6: For a read with `busy` high, every bit other than 7, 6, 15 and 14 equals the same bit of `last_word`.
- R7: The toggle bit clears whenever `busy` is low. The first new access after `busy` rises therefore returns 1 in bits 6 and 14. Once `busy` is low, reads return true array data again.
- R8: For a read with `busy` low and `id_mode` high, `addr0` = 0 returns 16'h001F and `addr0` = 1 returns 16'h0025.
- R9: When `busy` and `id_mode` are both high, the read returns the status word of R3, R4 and R6, and not an identification code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Chip select, active high |
| oe | input | 1 | Output enable, active high |
| busy | input | 1 | Internal program cycle in progress |
| id_mode | input | 1 | Identification mode is on |
| addr0 | input | 1 | Address bit 0, selects the identification code |
| last_word | input | 16 | Last word loaded for programming |
| array_word | input | 16 | Word read from the array |
| rd_word | output | 16 | Registered read result |
| rd_drive | output | 1 | Registered output-drive qualifier |

## Verification
Two functions can meet in one cycle. A read can arrive with both `busy` and `id_mode` high. Separately, a new access can begin in the same cycle that `busy` falls, so a toggle flip and the toggle clear compete. The bench provokes the first case by raising identification mode during a busy poll. It provokes the second by ending the busy period on a fresh strobe edge and then polling again. In both cases the scoreboard expects the status word over the code and a cleared toggle over the flip, and it checks the first toggle value after busy rises again.

// File: rtl/flash_rdmux_pkg.sv
package flash_rdmux_pkg;
   typedef enum logic [1:0] {
      SRC_NONE   = 2'd0,
      SRC_ARRAY  = 2'd1,
      SRC_STATUS = 2'd2,
      SRC_IDENT  = 2'd3
   } rd_src_e;
endpackage

// File: rtl/rdmux_access_track.sv
// Detects the start of a read access and keeps the busy-time toggle bit.
module rdmux_access_track (
   input  logic clk,
   input  logic rst_n,
   input  logic sel,
   input  logic oe,
   input  logic busy,
   output logic strobe,
   output logic tog_nx
);
   logic strobe_q;
   logic tog_q;
   logic rise;

   assign strobe = sel & oe;
   assign rise   = strobe & ~strobe_q;

   always_comb begin
      if (!busy)     tog_nx = 1'b0;
      else if (rise) tog_nx = ~tog_q;
      else           tog_nx = tog_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strobe_q <= 1'b0;
         tog_q    <= 1'b0;
      end else begin
         strobe_q <= strobe;
         tog_q    <= tog_nx;
      end
   end
endmodule

// File: rtl/rdmux_status_lane.sv
// Builds the busy-time status for one byte lane.
module rdmux_status_lane #(
   parameter int unsigned LANE_W     = 8,
   parameter int unsigned POLL_BIT   = 7,
   parameter int unsigned TOGGLE_BIT = 6
) (
   input  logic [LANE_W-1:0] last_lane,
   input  logic              tog,
   output logic [LANE_W-1:0] stat_lane
);
   always_comb begin
      stat_lane             = last_lane;
      stat_lane[POLL_BIT]   = ~last_lane[POLL_BIT];
      stat_lane[TOGGLE_BIT] = tog;
   end
endmodule

// File: rtl/rdmux_ident.sv
// Selects the manufacturer or device code from address bit 0.
module rdmux_ident #(
   parameter int unsigned DW       = 16,
   parameter int unsigned MFR_CODE = 'h1F,
   parameter int unsigned DEV_CODE = 'h25
) (
   input  logic          addr0,
   output logic [DW-1:0] code
);
   localparam logic [DW-1:0] MFR_W = DW'(MFR_CODE);
   localparam logic [DW-1:0] DEV_W = DW'(DEV_CODE);

   assign code = addr0 ? DEV_W : MFR_W;
endmodule

// File: rtl/flash_rdmux.sv
module flash_rdmux
   import flash_rdmux_pkg::*;
#(
   parameter int unsigned DW         = 16,
   parameter int unsigned LANE_W     = 8,
   parameter int unsigned POLL_BIT   = 7,
   parameter int unsigned TOGGLE_BIT = 6,
   parameter int unsigned MFR_CODE   = 'h1F,
   parameter int unsigned DEV_CODE   = 'h25
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sel,
   input  logic          oe,
   input  logic          busy,
   input  logic          id_mode,
   input  logic          addr0,
   input  logic [DW-1:0] last_word,
   input  logic [DW-1:0] array_word,
   output logic [DW-1:0] rd_word,
   output logic          rd_drive
);
   localparam int unsigned NLANES = DW / LANE_W;

   // elaboration-time parameter checks
   generate
      if (LANE_W == 0 || (DW % LANE_W) != 0) begin : g_bad_lane
         $error("flash_rdmux: DW must be a whole number of lanes");
      end
      if (POLL_BIT >= LANE_W || TOGGLE_BIT >= LANE_W) begin : g_bad_bit
         $error("flash_rdmux: status bit outside lane");
      end
      if (POLL_BIT == TOGGLE_BIT) begin : g_bad_same
         $error("flash_rdmux: poll and toggle bits must differ");
      end
   endgenerate

   logic          strobe;
   logic          tog_nx;
   logic [DW-1:0] stat_word;
   logic [DW-1:0] id_word;
   logic [DW-1:0] next_word;
   rd_src_e       src;

   rdmux_access_track u_track (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (sel),
      .oe     (oe),
      .busy   (busy),
      .strobe (strobe),
      .tog_nx (tog_nx)
   );

   generate
      for (genvar ln = 0; ln < NLANES; ln++) begin : g_lane
         rdmux_status_lane #(
            .LANE_W     (LANE_W),
            .POLL_BIT   (POLL_BIT),
            .TOGGLE_BIT (TOGGLE_BIT)
         ) u_lane (
            .last_lane (last_word[ln*LANE_W +: LANE_W]),
            .tog       (tog_nx),
            .stat_lane (stat_word[ln*LANE_W +: LANE_W])
         );
      end
   endgenerate

   rdmux_ident #(
      .DW       (DW),
      .MFR_CODE (MFR_CODE),
      .DEV_CODE (DEV_CODE)
   ) u_ident (
      .addr0 (addr0),
      .code  (id_word)
   );

   // source priority: no strobe, then busy poll, then identification, then array
   always_comb begin
      if (!strobe)      src = SRC_NONE;
      else if (busy)    src = SRC_STATUS;
      else if (id_mode) src = SRC_IDENT;
      else              src = SRC_ARRAY;
   end

   always_comb begin
      unique case (src)
         SRC_STATUS: next_word = stat_word;
         SRC_IDENT:  next_word = id_word;
         SRC_ARRAY:  next_word = array_word;
         default:    next_word = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_word  <= '0;
         rd_drive <= 1'b0;
      end else begin
         rd_word  <= next_word;
         rd_drive <= (src != SRC_NONE);
      end
   end
endmodule

// File: rtl/flash_rdmux_chk.sv
module flash_rdmux_chk #(
   parameter int unsigned DW         = 16,
   parameter int unsigned LANE_W     = 8,
   parameter int unsigned POLL_BIT   = 7,
   parameter int unsigned TOGGLE_BIT = 6,
   parameter int unsigned MFR_CODE   = 'h1F,
   parameter int unsigned DEV_CODE   = 'h25
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel,
   input logic          oe,
   input logic          busy,
   input logic          id_mode,
   input logic          addr0,
   input logic [DW-1:0] last_word,
   input logic [DW-1:0] array_word,
   input logic [DW-1:0] rd_word,
   input logic          rd_drive
);
   localparam int unsigned HI_POLL = DW - LANE_W + POLL_BIT;
   localparam int unsigned HI_TOG  = DW - LANE_W + TOGGLE_BIT;

   function automatic logic [DW-1:0] plain_mask();
      logic [DW-1:0] m;
      m = '1;
      for (int i = 0; i < DW / LANE_W; i++) begin
         m[i*LANE_W + POLL_BIT]   = 1'b0;
         m[i*LANE_W + TOGGLE_BIT] = 1'b0;
      end
      return m;
   endfunction

   localparam logic [DW-1:0] KEEP = plain_mask();

   logic rd_on;
   assign rd_on = sel & oe;

   assert_idle_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_on |=> (rd_word == '0) && !rd_drive);

   assert_array_path_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_on && !busy && !id_mode) |=> rd_drive && (rd_word == $past(array_word)));

   assert_poll_invert_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_on && busy) |=> (rd_word[POLL_BIT] == !$past(last_word[POLL_BIT]))
                        && (rd_word[HI_POLL] == !$past(last_word[HI_POLL])));

   assert_toggle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_on && $past(rd_on) && busy && $past(busy))
         |=> (rd_word[TOGGLE_BIT] == $past(rd_word[TOGGLE_BIT]))
          && (rd_word[HI_TOG] == $past(rd_word[HI_TOG])));

   assert_plain_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_on && busy) |=> ((rd_word & KEEP) == ($past(last_word) & KEEP)));

   assert_first_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_on && !$past(rd_on) && busy && !$past(busy))
         |=> rd_word[TOGGLE_BIT] && rd_word[HI_TOG]);

   assert_ident_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_on && !busy && id_mode)
         |=> rd_word == ($past(addr0) ? DW'(DEV_CODE) : DW'(MFR_CODE)));
endmodule

bind flash_rdmux flash_rdmux_chk #(
   .DW         (DW),
   .LANE_W     (LANE_W),
   .POLL_BIT   (POLL_BIT),
   .TOGGLE_BIT (TOGGLE_BIT),
   .MFR_CODE   (MFR_CODE),
   .DEV_CODE   (DEV_CODE)
) u_chk (.*);

// File: tb/sim_flash_rdmux.sv
`timescale 1ns/1ps
module sim_flash_rdmux;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0, oe = 1'b0, busy = 1'b0, id_mode = 1'b0, addr0 = 1'b0;
   logic [15:0] last_word = '0, array_word = '0;
   logic [15:0] rd_word;
   logic        rd_drive;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [16:0] exp_q[$];
   string       tag_q[$];

   // bench model state
   logic m_prev = 1'b0;
   logic m_tog  = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   flash_rdmux u0 (
      .clk(clk), .rst_n(rst_n), .sel(sel), .oe(oe), .busy(busy),
      .id_mode(id_mode), .addr0(addr0), .last_word(last_word),
      .array_word(array_word), .rd_word(rd_word), .rd_drive(rd_drive)
   );

   task automatic check(input string tag, input logic [16:0] act, input logic [16:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%05h expected=%05h", tag, act, exp);
      end
   endtask

   // driver: apply one cycle of inputs and queue the expected result
   task automatic drive(input logic s, input logic o, input logic b, input logic idm,
                        input logic a0, input logic [15:0] lw, input logic [15:0] aw,
                        input string tag);
      logic        on, rise;
      logic [15:0] w;
      @(negedge clk);
      sel = s; oe = o; busy = b; id_mode = idm; addr0 = a0;
      last_word = lw; array_word = aw;
      on   = s & o;
      rise = on & ~m_prev;
      if (!b)        m_tog = 1'b0;
      else if (rise) m_tog = ~m_tog;
      m_prev = on;
      if (!on) w = 16'h0000;
      else if (b) begin
         w = lw;
         w[7]  = ~lw[7];  w[15] = ~lw[15];
         w[6]  = m_tog;   w[14] = m_tog;
      end
      else if (idm) w = a0 ? 16'h0025 : 16'h001F;
      else w = aw;
      exp_q.push_back({on, w});
      tag_q.push_back(tag);
   endtask

   // monitor: compare one queued item per clock
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) begin
         logic [16:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, {rd_drive, rd_word}, e);
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 check("R1 reset", {rd_drive, rd_word}, 17'h0);
      @(negedge clk);
      rst_n = 1'b1;

      drive(0,0,0,0,0,16'h0000,16'h1111,"R1 no strobe");
      drive(1,0,0,0,0,16'h0000,16'h2222,"R1 oe low");
      drive(0,1,0,0,0,16'h0000,16'h3333,"R1 sel low");
      drive(1,1,0,0,0,16'h0000,16'hBEEF,"R2 array");
      drive(1,1,0,0,0,16'h0000,16'h0001,"R2 array next");
      drive(1,1,0,1,0,16'h0000,16'hFFFF,"R8 mfr code");
      drive(1,1,0,1,1,16'h0000,16'hFFFF,"R8 dev code");
      // busy with strobe already held: no new access
      drive(1,1,1,0,0,16'hA5C3,16'hFFFF,"R3 R6 poll held");
      drive(1,0,1,0,0,16'hA5C3,16'hFFFF,"R1 oe off in busy");
      drive(1,1,1,0,0,16'hA5C3,16'hFFFF,"R5 oe toggled");
      drive(1,1,1,0,0,16'hA5C3,16'hFFFF,"R4 strobe held");
      drive(0,1,1,0,0,16'hA5C3,16'hFFFF,"R1 sel off in busy");
      drive(1,1,1,0,0,16'h3C5A,16'hFFFF,"R5 sel toggled");
      drive(0,0,1,0,0,16'h3C5A,16'hFFFF,"R1 both off");
      drive(1,1,1,0,0,16'h3C5A,16'hFFFF,"R5 both toggled");
      drive(0,0,1,1,1,16'h3C5A,16'hFFFF,"R1 off before id");
      drive(1,1,1,1,1,16'h3C5A,16'hFFFF,"R9 busy over id");
      drive(0,0,1,0,0,16'h3C5A,16'hFFFF,"R1 off before end");
      // new access in the same cycle busy falls
      drive(1,1,0,0,0,16'h3C5A,16'h5A5A,"R7 busy ends");
      drive(0,0,1,0,0,16'h8040,16'h5A5A,"R1 off busy again");
      drive(1,1,1,0,0,16'h8040,16'h5A5A,"R7 first toggle");
      drive(0,0,1,0,0,16'h8040,16'h5A5A,"R1 off");
      drive(1,1,1,0,0,16'h8040,16'h5A5A,"R4 second toggle");
      drive(0,0,0,0,0,16'h0000,16'h0000,"R1 final idle");
      repeat (3) @(posedge clk);
      #2;
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule